// File: doc/BRIEF.md
# Mantissa Normalizer With Exponent Adjust

This block takes a 128-bit mantissa, viewed as four 32-bit words with word 0 the most significant, together with a 16-bit two's complement exponent, and returns the same value in normalized form: the leading one is placed exactly at a fixed hidden-bit position inside word 0, and the exponent is adjusted so that mantissa times two to the exponent is unchanged. The hidden-bit position is a parameter. Its default is bit 19 of word 0, which is bit 115 of the 128-bit bus.

Three cases are handled. Deeply small inputs, where word 0 is zero, are first moved up by whole words. Small inputs, where the top word is below the hidden-one weight, are shifted left. Oversized inputs, where the top word is at least twice the hidden-one weight, are shifted right. An all-zero mantissa is reported through a zero flag. The leading-one search is a priority encoder, so one result is produced per clock with one cycle of latency. The block sits in a floating-point datapath between an arithmetic stage and a rounding stage.

Top module: `mant_norm`

## Requirements
- R1: For every accepted nonzero mantissa, the registered output has bit 115 (word 0 bit 19 under the defaults) set and every bit above it clear.
- R2: An all-zero input mantissa gives out_zero=1, an all-zero out_mant and out_exp equal to in_exp. Any nonzero input gives out_zero=0.
- R3: When word 0 (bits 127:96) is zero, the first nonzero lower word is moved up into word 0, the words below it follow, and zeros fill in from the bottom. The exponent drops by 32 for each word position moved, before any bit shift is applied.
- R4: When word 0 is at least twice the hidden-one weight (2^20 under the defaults), the words are shifted right until the leading one reaches the hidden bit, and the exponent rises by the shift count. The incoming word 3 (bits 31:0) is discarded, and the bits shifted out of word 2 land at the top of word 3.
- R5: When word 0 is nonzero but below the hidden-one weight, the mantissa is shifted left until the leading one reaches the hidden bit. The exponent falls by the shift count, bits are pulled up from the lower words, and zeros fill in at bit 0.
- R6: An input whose leading one already sits at the hidden bit is passed through with mantissa and exponent unchanged.
- R7: The output value equals the input value, out_mant*2^out_exp = in_mant*2^in_exp. The exponent arithmetic wraps modulo 2^16. In the R4 case this holds when the input word 3 is zero.
- R8: Outputs are registered with one cycle of latency. out_vld equals the previous cycle's in_vld. Without in_vld, out_mant, out_exp and out_zero hold their values. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input operand is valid this cycle |
| in_mant | input | 128 | Input mantissa, word 0 in bits 127:96 |
| in_exp | input | 16 | Input exponent, two's complement |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_mant | output | 128 | Normalized mantissa |
| out_exp | output | 16 | Adjusted exponent, two's complement |
| out_zero | output | 1 | Input mantissa was all zero |

## Verification
Directed operands place a single leading one in each word, at the hidden bit, just above and just below it, at bit 31 of word 0 and at bit 0 of word 3. These separate the coarse word move from the fine left and right shifts and catch off-by-one errors in the shift count. An oversized operand with junk in word 3 shows that word 3 is dropped, an all-zero operand with a nonzero exponent shows that the exponent is kept, and an exponent near -32768 shows the wraparound. Random operands with random top-bit positions and gaps in in_vld are then checked every cycle against a behavioural model that finds the leading one over the whole 128-bit value and checks value preservation and the hold behaviour.

// File: rtl/mant_norm.sv
module mant_norm #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int HID_POS = 19,
  parameter int EXP_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_vld,
  input  logic [WORD_W*N_WORDS-1:0]   in_mant,
  input  logic [EXP_W-1:0]            in_exp,
  output logic                        out_vld,
  output logic [WORD_W*N_WORDS-1:0]   out_mant,
  output logic [EXP_W-1:0]            out_exp,
  output logic                        out_zero
);
  localparam int MW = WORD_W * N_WORDS;

  logic [MW-1:0]     coarse, tail_clr, nxt_mant;
  logic [WORD_W-1:0] top;
  logic [EXP_W-1:0]  nxt_exp;
  logic              all_zero;
  int                k, p, adj;

  always_comb begin
    k = 0;
    all_zero = 1'b1;
    for (int i = 0; i < N_WORDS; i++) begin
      if (all_zero && (in_mant[MW-1-i*WORD_W -: WORD_W] != '0)) begin
        k = i;
        all_zero = 1'b0;
      end
    end
  end

  assign coarse   = in_mant << (k * WORD_W);
  assign top      = coarse[MW-1 -: WORD_W];
  assign tail_clr = {coarse[MW-1:WORD_W], {WORD_W{1'b0}}};

  always_comb begin
    p = -1;
    for (int i = 0; i < WORD_W; i++)
      if (top[i]) p = i;
  end

  always_comb begin
    adj = -(k * WORD_W);
    nxt_mant = coarse;
    if (all_zero) begin
      adj = 0;
      nxt_mant = '0;
    end else if (p > HID_POS) begin
      nxt_mant = tail_clr >> (p - HID_POS);
      adj = adj + (p - HID_POS);
    end else if (p < HID_POS) begin
      nxt_mant = coarse << (HID_POS - p);
      adj = adj - (HID_POS - p);
    end
  end

  assign nxt_exp = in_exp + EXP_W'(adj);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_mant <= '0;
      out_exp  <= '0;
      out_zero <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_mant <= nxt_mant;
        out_exp  <= nxt_exp;
        out_zero <= all_zero;
      end
    end
  end
endmodule

// File: rtl/mant_norm_chk.sv
module mant_norm_chk #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int HID_POS = 19,
  parameter int EXP_W   = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_vld,
  input logic [WORD_W*N_WORDS-1:0] in_mant,
  input logic [EXP_W-1:0]          in_exp,
  input logic                      out_vld,
  input logic [WORD_W*N_WORDS-1:0] out_mant,
  input logic [EXP_W-1:0]          out_exp,
  input logic                      out_zero
);
  localparam int MW = WORD_W * N_WORDS;
  localparam int HG = MW - WORD_W + HID_POS;

  logic [WORD_W-1:0] in_top;
  assign in_top = in_mant[MW-1 -: WORD_W];

  a_r1_lead_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_zero) |-> (out_mant[HG] && ((out_mant >> (HG + 1)) == '0)));

  a_r2_zero_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_mant == '0) |=> (out_zero && out_mant == '0 && out_exp == $past(in_exp)));

  a_r2_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_mant != '0) |=> !out_zero);

  a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_top[HID_POS] && ((in_top >> (HID_POS + 1)) == '0))
    |=> (out_mant == $past(in_mant) && out_exp == $past(in_exp)));

  a_r8_vld: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(out_mant) && $stable(out_exp) && $stable(out_zero)));
endmodule

bind mant_norm mant_norm_chk #(
  .WORD_W(WORD_W), .N_WORDS(N_WORDS), .HID_POS(HID_POS), .EXP_W(EXP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mant(in_mant), .in_exp(in_exp),
  .out_vld(out_vld), .out_mant(out_mant), .out_exp(out_exp), .out_zero(out_zero)
);

// File: tb/test_mant_norm.sv
module test_mant_norm;
  localparam int WW = 32, NW = 4, HID = 19, EW = 16;
  localparam int MW = WW * NW;
  localparam int HG = MW - WW + HID;

  logic          clk = 1'b0, rst_n = 1'b0, in_vld = 1'b0;
  logic [MW-1:0] in_mant = '0;
  logic [EW-1:0] in_exp = '0;
  logic          out_vld, out_zero;
  logic [MW-1:0] out_mant;
  logic [EW-1:0] out_exp;

  mant_norm #(.WORD_W(WW), .N_WORDS(NW), .HID_POS(HID), .EXP_W(EW)) i_mant_norm (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mant(in_mant), .in_exp(in_exp),
    .out_vld(out_vld), .out_mant(out_mant), .out_exp(out_exp), .out_zero(out_zero));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct packed {
    logic          zero;
    logic [EW-1:0] e;
    logic [MW-1:0] m;
  } ref_t;

  function automatic ref_t ref_norm(logic [MW-1:0] m, logic [EW-1:0] e);
    ref_t r;
    logic [MW-1:0] mm;
    int g;
    g = -1;
    for (int i = 0; i < MW; i++) if (m[i]) g = i;
    r = '0;
    if (g < 0) begin
      r.zero = 1'b1;
      r.e = e;
    end else if (g > HG) begin
      mm = m;
      mm[WW-1:0] = '0;
      r.m = mm >> (g - HG);
      r.e = e + EW'(g - HG);
    end else begin
      r.m = m << (HG - g);
      r.e = e - EW'(HG - g);
    end
    return r;
  endfunction

  function automatic string tag_of(logic [MW-1:0] m);
    int g;
    g = -1;
    for (int i = 0; i < MW; i++) if (m[i]) g = i;
    if (g < 0) return "R2";
    if (g > HG) return "R4";
    if (g == HG) return "R6";
    if (g >= MW - WW) return "R5";
    return "R3";
  endfunction

  // behavioural model state
  logic          m_vld = 0, m_zero = 0, m_lastv = 0;
  logic [MW-1:0] m_mant = '0, p_mant = '0;
  logic [EW-1:0] m_exp = '0, p_exp = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld <= 0; m_zero <= 0; m_mant <= '0; m_exp <= '0; m_lastv <= 0;
    end else begin
      ref_t r;
      r = ref_norm(in_mant, in_exp);
      m_vld <= in_vld;
      m_lastv <= in_vld;
      if (in_vld) begin
        m_mant <= r.m; m_exp <= r.e; m_zero <= r.zero;
        p_mant <= in_mant; p_exp <= in_exp;
      end
    end
  end

  task automatic chk(string tag, logic [MW-1:0] act, logic [MW-1:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  task automatic compare();
    string t;
    int d;
    t = m_lastv ? tag_of(p_mant) : "R8";
    chk("R8 out_vld", MW'(out_vld), MW'(m_vld));
    chk({t, " out_mant"}, out_mant, m_mant);
    chk({t, " out_exp"}, MW'(out_exp), MW'(m_exp));
    chk({t, " out_zero"}, MW'(out_zero), MW'(m_zero));
    if (out_vld && !out_zero) begin
      chk("R1 lead one", MW'(out_mant >> HG), MW'(1));
      d = int'($signed(out_exp - p_exp));
      if (d <= 0) chk("R7 value", out_mant >> (-d), p_mant);
      else if (p_mant[WW-1:0] == '0) chk("R7 value", out_mant << d, p_mant);
    end
  endtask

  task automatic drive(logic v, logic [MW-1:0] m, logic [EW-1:0] e);
    @(negedge clk);
    compare();
    in_vld = v; in_mant = m; in_exp = e;
  endtask

  function automatic logic [MW-1:0] rnd_mant();
    logic [MW-1:0] m;
    int top;
    m = {$urandom, $urandom, $urandom, $urandom};
    top = int'($urandom_range(MW - 1, 0));
    m = m & ({MW{1'b1}} >> (MW - 1 - top));
    if ($urandom_range(3, 0) == 0) m[WW-1:0] = '0;
    return m;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset vld", MW'(out_vld), '0);
    chk("R8 reset mant", out_mant, '0);
    chk("R8 reset exp", MW'(out_exp), '0);
    chk("R8 reset zero", MW'(out_zero), '0);
    rst_n = 1'b1;
    drive(1, '0, 16'sd77);
    drive(1, MW'(1) << HG, 16'sd5);
    drive(1, MW'(1) << (HG + 1), 16'sd5);
    drive(1, MW'(1) << (HG - 1), 16'sd5);
    drive(1, {32'hFFFF_FFFF, 32'h1234_5678, 32'h9ABC_DEF0, 32'hDEAD_BEEF}, 16'sd0);
    drive(1, {32'h0, 32'h8000_0001, 32'h0, 32'h0}, 16'sd100);
    drive(1, {32'h0, 32'h0, 32'h0007_0000, 32'h5}, -16'sd3);
    drive(1, {32'h0, 32'h0, 32'h0, 32'h1}, 16'sd0);
    drive(1, {32'h0, 32'h0, 32'h0, 32'h1}, -16'sd32768);
    drive(1, {32'h0000_0001, 32'hFFFF_FFFF, 32'h0, 32'h8000_0000}, 16'sd10);
    drive(0, {32'h1, 32'h0, 32'h0, 32'h0}, 16'sd9);
    drive(0, '0, 16'sd0);
    drive(1, {32'h0000_0100, 32'h0, 32'h0, 32'h0}, 16'sd1);
    for (int n = 0; n < 3000; n++)
      drive($urandom_range(3, 0) != 0, rnd_mant(), EW'($urandom));
    drive(0, '0, '0);
    drive(0, '0, '0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule